// File: doc/BRIEF.md
# Byte-Program Flash Controller with Write-Status Polling

This block controls an on-chip code flash array through a parallel programming port. An address bus, a data bus, a two-bit mode select, a program-enable level and a program strobe drive it. A rising edge on the strobe starts one operation: a byte program of the addressed location, or an erase of the whole array. The array is modelled as a register file. It comes out of reset fully erased, with every byte reading FFh.

Each operation is self-timed. After the strobe edge the controller stays busy for a fixed number of clock cycles, then commits the result and becomes ready again. A byte program can only turn ones into zeros, so a byte that already holds data needs a chip erase before it can take a new value. Software tracks a write by reading the byte it is writing. During the write, bit 7 of the read data is the inverse of bit 7 of the value being written. When the write finishes, the read returns the true stored byte.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset every byte of the array reads FFh and `busy_o` is low.
- R2: A rising edge of `strobe_i` while `pgm_en_i` is high, `busy_o` is low and `mode_i` is 2'b01 (byte program) starts a write. `busy_o` is high from the next clock edge for exactly PROG_CYC cycles.
- R3: When a byte program completes, the addressed byte holds its old value ANDed with the latched data byte, so bits can only be cleared.
- R4: While a byte program is in progress, a read of the address being written shows the inverse of bit 7 of the written data on `rdata_o[7]`. Bits 6..0 are don't-care.
- R5: While a byte program is in progress, a read of any other address returns that byte's stored value.
- R6: Once busy falls, a read of the written address returns the stored value, and a new operation may start.
- R7: Strobe edges that arrive while `busy_o` is high are ignored and change no byte.
- R8: A strobe held high across the end of a write causes no second write. Only its rising edge counts.
- R9: A strobe edge with `pgm_en_i` low, or with `mode_i` equal to 2'b00 or 2'b11 (read or no operation), starts nothing and changes no byte.
- R10: With `mode_i` equal to 2'b10, a strobe edge starts a chip erase. `busy_o` is high for ERASE_CYC cycles, `rdata_o[7]` reads 0 at every address during the erase, and every byte reads FFh afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Byte address for program and for read |
| data_i | input | 8 | Data byte to program |
| mode_i | input | 2 | 00 read, 01 byte program, 10 chip erase, 11 no operation |
| pgm_en_i | input | 1 | Program enable level |
| strobe_i | input | 1 | Program strobe; the rising edge is used |
| rdata_o | output | 8 | Read data, or the polling value during a write |
| busy_o | output | 1 | High while a self-timed operation runs |

## Verification
Byte programs are run on blank bytes, on bytes that already hold data (to show the AND merge against a plain overwrite), and with all-zero and all-one data. Data with bit 7 set and data with bit 7 clear are both written, so the polling bit is shown to be inverted and not a constant. Reads of another address during a write tell true data apart from polling data. Strobes that arrive while busy, with enable low, in read mode, or held high over the end of a write each confirm that no extra write happens. A chip erase followed by a reprogram closes the run.

// File: rtl/flash_ctrl_pkg.sv
// Shared mode and operation encodings for the flash programming controller.
package flash_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'b00,
        MODE_PROG  = 2'b01,
        MODE_ERASE = 2'b10,
        MODE_NONE  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10
    } op_e;
endpackage

// File: rtl/flash_strobe_edge.sv
// Rising-edge detector for the program strobe.
// Assumes the strobe is already synchronous to clk.
module flash_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic strobe_q;

    // Remember the strobe level of the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    assign rise_o = strobe_i & ~strobe_q;

    // R8: an edge lasts one cycle, even when the strobe is held
    assert_single_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/flash_op_seq.sv
// Self-timed operation sequencer: accepts a start on a qualified strobe edge,
// counts the operation length and pulses commit in the last busy cycle.
// Assumes PROG_CYC and ERASE_CYC are both at least 1.
module flash_op_seq
    import flash_ctrl_pkg::*;
#(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise_i,
    input  logic  pgm_en_i,
    input  mode_e mode_i,
    output logic  start_o,
    output logic  busy_o,
    output op_e   op_o,
    output logic  commit_o
);
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    op_e           op_q;

    // Qualify the strobe edge: enabled, idle, and a mode that writes.
    assign start_o = rise_i & pgm_en_i & ~busy_q &
                     ((mode_i == MODE_PROG) || (mode_i == MODE_ERASE));

    // Load the length on start and count down to the commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_IDLE;
        end else if (start_o) begin
            busy_q <= 1'b1;
            op_q   <= (mode_i == MODE_PROG) ? OP_PROG : OP_ERASE;
            cnt_q  <= (mode_i == MODE_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                op_q   <= OP_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o   = busy_q;
    assign op_o     = op_q;
    assign commit_o = busy_q && (cnt_q == '0);

    // R2: the remaining count never exceeds the longest operation
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (int'(cnt_q) < MAXC));
    // R2: a running operation keeps busy until its commit cycle
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !commit_o) |=> busy_q);
    // R6: busy drops right after the commit
    assert_ready_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !busy_q);
endmodule

// File: rtl/flash_array.sv
// Byte-wide register-file model of the flash array. Latches the target on
// start, applies the AND merge or the full erase on commit, and forms the
// polling read value while an operation runs.
// Assumes start and commit never fall in the same cycle.
module flash_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic          commit_pgm_i,
    input  logic          commit_erase_i,
    input  logic          poll_pgm_i,
    input  logic          poll_erase_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] waddr_q;
    logic [7:0]    wdata_q;

    // Capture address and data of the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            wdata_q <= '0;
        end else if (latch_i) begin
            waddr_q <= waddr_i;
            wdata_q <= wdata_i;
        end
    end

    // Array update: erased on reset and on erase commit, AND-merge on program.
    always_ff @(posedge clk) begin
        if (!rst_n || commit_erase_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit_pgm_i) begin
            mem[waddr_q] <= mem[waddr_q] & wdata_q;
        end
    end

    // Read path with the polling substitution on bit 7.
    always_comb begin
        rdata_o = mem[raddr_i];
        if (poll_erase_i)
            rdata_o[7] = 1'b0;
        else if (poll_pgm_i && (raddr_i == waddr_q))
            rdata_o[7] = ~wdata_q[7];
    end

    // R3: a program commit never sets a bit that was clear
    assert_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pgm_i |=> ((~$past(mem[waddr_q]) & mem[waddr_q]) == 8'h00));
    // R3: the committed byte has no one where the data had a zero
    assert_and_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pgm_i |=> ((mem[waddr_q] & ~wdata_q) == 8'h00));
    // R10: an erase commit leaves the end bytes blank
    assert_erased_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_erase_i |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flash_pgm_ctrl.sv
// Top level of the byte-program flash controller: strobe edge detect,
// self-timed sequencer and array model.
// Assumes all inputs are synchronous to clk.
module flash_pgm_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int AW        = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic [1:0]    mode_i,
    input  logic          pgm_en_i,
    input  logic          strobe_i,
    output logic [7:0]    rdata_o,
    output logic          busy_o
);
    logic  rise;
    logic  start;
    logic  commit;
    op_e   op;
    mode_e mode;

    assign mode = mode_e'(mode_i);

    flash_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .rise_o   (rise)
    );

    flash_op_seq #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .pgm_en_i (pgm_en_i),
        .mode_i   (mode),
        .start_o  (start),
        .busy_o   (busy_o),
        .op_o     (op),
        .commit_o (commit)
    );

    flash_array #(.AW(AW)) u_array (
        .clk            (clk),
        .rst_n          (rst_n),
        .latch_i        (start),
        .waddr_i        (addr_i),
        .wdata_i        (data_i),
        .commit_pgm_i   (commit && (op == OP_PROG)),
        .commit_erase_i (commit && (op == OP_ERASE)),
        .poll_pgm_i     (busy_o && (op == OP_PROG)),
        .poll_erase_i   (busy_o && (op == OP_ERASE)),
        .raddr_i        (addr_i),
        .rdata_o        (rdata_o)
    );

    // R9: busy rises only after an enabled strobe edge
    assert_start_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(rise && pgm_en_i));
    // R7: an edge while busy does not restart the operation
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !commit) |=> $stable(op));
endmodule

// File: tb/flash_pgm_ctrl_tb_top.sv
module flash_pgm_ctrl_tb_top;
    localparam int AW = 6;
    localparam int PC = 8;
    localparam int EC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data = '0;
    logic [1:0]    mode = 2'b00;
    logic          en = 1'b0;
    logic          strobe = 1'b0;
    logic [7:0]    rdata;
    logic          busy;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    flash_pgm_ctrl #(.AW(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(data),
        .mode_i(mode), .pgm_en_i(en), .strobe_i(strobe),
        .rdata_o(rdata), .busy_o(busy)
    );

    // {addr, data, expected read after write}
    localparam logic [23:0] VEC [6] = '{
        {8'd3,  8'hA5, 8'hA5},
        {8'd3,  8'hF0, 8'hA0},
        {8'd63, 8'h00, 8'h00},
        {8'd0,  8'h7F, 8'h7F},
        {8'd10, 8'hFF, 8'hFF},
        {8'd10, 8'h3C, 8'h3C}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_at(input int a);
        addr = AW'(a);
        #1;
    endtask

    // One-cycle strobe; returns at the negedge after the start edge.
    task automatic pulse(input logic [1:0] m, input int a, input logic [7:0] d, input logic e);
        @(negedge clk);
        mode = m; addr = AW'(a); data = d; en = e; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", {7'b0, busy}, 8'h00);
        read_at(0);  check("R1 byte0", rdata, 8'hFF);
        read_at(37); check("R1 byte37", rdata, 8'hFF);
        read_at(63); check("R1 byte63", rdata, 8'hFF);

        // Vector table: program, poll, wait, read back (R2 R3 R4 R6)
        for (int i = 0; i < 6; i++) begin
            logic [7:0] va, vd, ve;
            {va, vd, ve} = VEC[i];
            pulse(2'b01, int'(va), vd, 1'b1);
            check("R2 busy after start", {7'b0, busy}, 8'h01);
            read_at(int'(va));
            check("R4 poll bit7", {7'b0, rdata[7]}, {7'b0, ~vd[7]});
            repeat (PC - 1) @(negedge clk);
            check("R2 busy last cycle", {7'b0, busy}, 8'h01);
            @(negedge clk);
            check("R2 busy cleared", {7'b0, busy}, 8'h00);
            read_at(int'(va));
            check("R3 R6 read back", rdata, ve);
        end

        // R5: another address reads true data during a write
        pulse(2'b01, 15, 8'h12, 1'b1);
        read_at(3); check("R5 other addr", rdata, 8'hA0);
        read_at(0); check("R5 other addr bit7 clear", rdata, 8'h7F);
        repeat (PC) @(negedge clk);
        read_at(15); check("R6 written byte", rdata, 8'h12);

        // R7: strobe while busy is ignored
        pulse(2'b01, 20, 8'h11, 1'b1);
        pulse(2'b01, 21, 8'h00, 1'b1);
        repeat (PC + 2) @(negedge clk);
        check("R7 idle", {7'b0, busy}, 8'h00);
        read_at(21); check("R7 untouched", rdata, 8'hFF);
        read_at(20); check("R7 first write", rdata, 8'h11);

        // R8: held strobe gives a single write
        @(negedge clk);
        mode = 2'b01; addr = AW'(30); data = 8'h0F; en = 1'b1; strobe = 1'b1;
        repeat (PC + 4) @(negedge clk);
        check("R8 no rewrite", {7'b0, busy}, 8'h00);
        strobe = 1'b0;
        read_at(30); check("R8 data", rdata, 8'h0F);

        // R9: disabled or read-mode strobes do nothing
        pulse(2'b01, 40, 8'h00, 1'b0);
        check("R9 enable low busy", {7'b0, busy}, 8'h00);
        read_at(40); check("R9 enable low byte", rdata, 8'hFF);
        pulse(2'b00, 41, 8'h00, 1'b1);
        check("R9 read mode busy", {7'b0, busy}, 8'h00);
        pulse(2'b11, 41, 8'h00, 1'b1);
        check("R9 none mode busy", {7'b0, busy}, 8'h00);
        read_at(41); check("R9 mode byte", rdata, 8'hFF);

        // R10: chip erase
        pulse(2'b10, 3, 8'h00, 1'b1);
        check("R10 busy", {7'b0, busy}, 8'h01);
        read_at(3); check("R10 poll bit7", {7'b0, rdata[7]}, 8'h00);
        repeat (EC - 1) @(negedge clk);
        check("R10 busy last cycle", {7'b0, busy}, 8'h01);
        @(negedge clk);
        check("R10 busy cleared", {7'b0, busy}, 8'h00);
        read_at(3);  check("R10 erased 3", rdata, 8'hFF);
        read_at(63); check("R10 erased 63", rdata, 8'hFF);
        read_at(30); check("R10 erased 30", rdata, 8'hFF);

        // R3 R6: reprogram after erase
        pulse(2'b01, 3, 8'h5A, 1'b1);
        repeat (PC) @(negedge clk);
        read_at(3); check("R3 after erase", rdata, 8'h5A);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule